// File: doc/BRIEF.md
# MSI Doorbell to Interrupt Translator

This block is a small register frame on a 32-bit register bus. Its main job is to turn message-signalled interrupt writes into interrupt pulses. A device writes an interrupt number into a doorbell register. The block subtracts a fixed base (the `BASE_SPI` parameter plus 32) from that number to get a line index. If the index falls inside the configured line count, the block drives a one-cycle pulse on that line of an output vector. The vector feeds shared-peripheral interrupt inputs elsewhere in the chip. Any number outside that window is dropped without a response.

Software can also read back the frame's geometry:
- A type register packs the first interrupt number above the line count.
- An interface identification register returns a fixed product code.
- A block of optional identification registers reads as zero.

The block handles bad offsets and bad access sizes quietly: reads return zero and writes are dropped. Each address is classified combinationally into one of five selections:
- `SEL_TYPE`
- `SEL_DOORBELL`
- `SEL_IFID`
- `SEL_IDBLK`
- `SEL_NONE`

A read latches its data one cycle after the read strobe. A doorbell write produces its pulse one cycle after the write strobe. The frame has no other state.

Top module: `msi_irq_xlate`

## Requirements
- R1: After reset, `irq_pulse` is all zero and `bus_rdata` is zero.
- R2: A 4-byte read at offset 0x008 returns `((BASE_SPI+32) << 16) | NUM_LINES` in `bus_rdata`, one cycle after the strobe.
- R3: A doorbell write at offset 0x040 takes `id = bus_wdata[9:0]`. When `BASE_SPI+32 <= id < BASE_SPI+32+NUM_LINES`, it raises bit `id-(BASE_SPI+32)` of `irq_pulse` for exactly one cycle, starting one cycle after the strobe.
- R4: A doorbell write whose id lies outside that window leaves `irq_pulse` all zero.
- R5: `bus_size` gives the access size in bytes. Writes are accepted only at size 2 or 4, and other sizes are dropped. At size 2, bits 31:16 of the data are ignored. At both sizes, bits above bit 9 do not affect the id.
- R6: A 4-byte read at offset 0xFCC returns 0x0510_0000.
- R7: A 4-byte read at any offset from 0xFD0 through 0xFFC returns zero.
- R8: A read with `bus_size` other than 4 returns zero, at any offset.
- R9: A read at any undecoded offset returns zero. A write at any offset other than 0x040 produces no pulse.
- R10: Doorbell writes on consecutive cycles each give their own single-cycle pulse, and at most one line is high in any cycle.
- R11: The parameters satisfy `NUM_LINES <= 128` and `BASE_SPI + 32 + NUM_LINES <= 1020`. Both conditions are checked at elaboration.
- R12: `bus_rdata` changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset within the 4 KB frame |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_size | input | 3 | Access size in bytes |
| bus_rdata | output | 32 | Registered read data |
| irq_pulse | output | NUM_LINES | One-cycle interrupt pulses |

## Verification
The bench uses a small frame (base 5, sixteen lines) and writes every one of the 1024 possible interrupt numbers to the doorbell. This separates the ids just below the window, the ids inside it and the ids just above it. It also exposes any off-by-one error at the ends of the window.

A second sweep reads every word offset of the frame. This tells the type and identification registers apart from the zero-filled identification block and from undecoded space.

Size sweeps on both the read and write paths separate accepted access sizes from dropped ones. A 2-byte write with its upper half filled with ones shows that the upper half is ignored. Back-to-back doorbell writes and a write-between-reads sequence separate one pulse per write and held read data from stretched or merged behaviour.

// File: rtl/msi_xlate_pkg.sv
package msi_xlate_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int ID_W   = 10;
    localparam int SPI_OFFSET = 32;
    localparam int MAX_LINES  = 128;
    localparam int MAX_ID     = 1020;

    localparam logic [ADDR_W-1:0] OFS_TYPE     = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_DOORBELL = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_IFID     = 12'hFCC;
    localparam logic [ADDR_W-1:0] OFS_IDBLK_LO = 12'hFD0;
    localparam logic [ADDR_W-1:0] OFS_IDBLK_HI = 12'hFFC;

    localparam logic [DATA_W-1:0] IFID_VALUE = 32'h0510_0000;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TYPE,
        SEL_DOORBELL,
        SEL_IFID,
        SEL_IDBLK
    } reg_sel_e;

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
    import msi_xlate_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if (addr == OFS_TYPE)
            sel = SEL_TYPE;
        else if (addr == OFS_DOORBELL)
            sel = SEL_DOORBELL;
        else if (addr == OFS_IFID)
            sel = SEL_IFID;
        else if (addr >= OFS_IDBLK_LO && addr <= OFS_IDBLK_HI)
            sel = SEL_IDBLK;
        else
            sel = SEL_NONE;
    end

endmodule

// File: rtl/msi_pulse_gen.sv
module msi_pulse_gen
    import msi_xlate_pkg::*;
#(
    parameter int BASE_SPI  = 0,
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fire,
    input  logic [ID_W-1:0]      id,
    output logic [NUM_LINES-1:0] pulse
);

    localparam int FIRST_ID = BASE_SPI + SPI_OFFSET;

    logic [31:0]          id_ext;
    logic [NUM_LINES-1:0] pulse_nxt;

    assign id_ext = {{(32-ID_W){1'b0}}, id};

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign pulse_nxt[i] = fire && (id_ext == 32'(FIRST_ID + i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse <= '0;
        else
            pulse <= pulse_nxt;
    end

    // R10
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse));

    // R3
    pulse_needs_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> pulse == '0);

endmodule

// File: rtl/msi_irq_xlate.sv
module msi_irq_xlate
    import msi_xlate_pkg::*;
#(
    parameter int BASE_SPI  = 0,
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [11:0]          bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    input  logic [2:0]           bus_size,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] irq_pulse
);

    localparam int FIRST_ID = BASE_SPI + SPI_OFFSET;
    localparam logic [DATA_W-1:0] TYPE_VALUE =
        (32'(FIRST_ID) << 16) | 32'(NUM_LINES);

    // R11
    initial begin
        lines_limit_chk: assert (NUM_LINES >= 1 && NUM_LINES <= MAX_LINES)
            else $error("NUM_LINES out of range");
        id_limit_chk: assert (FIRST_ID + NUM_LINES <= MAX_ID)
            else $error("interrupt window exceeds the id limit");
    end

    reg_sel_e         sel;
    logic             wr_size_ok;
    logic             rd_size_ok;
    logic             fire;
    logic [15:0]      low_half;
    logic [ID_W-1:0]  irq_id;
    logic [DATA_W-1:0] rd_value;
    logic             unused_wdata_bits;

    msi_reg_decode u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_size_ok = (bus_size == 3'd2) || (bus_size == 3'd4);
    assign rd_size_ok = (bus_size == 3'd4);
    assign low_half   = bus_wdata[15:0];
    assign irq_id     = low_half[ID_W-1:0];
    assign fire       = bus_wr && wr_size_ok && (sel == SEL_DOORBELL);
    assign unused_wdata_bits = ^{bus_wdata[31:16], low_half[15:ID_W]};

    msi_pulse_gen #(
        .BASE_SPI  (BASE_SPI),
        .NUM_LINES (NUM_LINES)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .id    (irq_id),
        .pulse (irq_pulse)
    );

    always_comb begin
        unique case (sel)
            SEL_TYPE:     rd_value = TYPE_VALUE;
            SEL_IFID:     rd_value = IFID_VALUE;
            SEL_IDBLK:    rd_value = '0;
            SEL_DOORBELL: rd_value = '0;
            SEL_NONE:     rd_value = '0;
            default:      rd_value = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_size_ok ? rd_value : '0;
    end

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R8
    rd_bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_size != 3'd4) |=> bus_rdata == '0);

    // R6
    ifid_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_size == 3'd4 && bus_addr == 12'hFCC)
            |=> bus_rdata == 32'h0510_0000);

    // R9
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 12'h040) |=> irq_pulse == '0);

    // R5
    wr_bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_size != 3'd2 && bus_size != 3'd4) |=> irq_pulse == '0);

endmodule

// File: tb/msi_irq_xlate_tb.sv
`timescale 1ns/1ps
module msi_irq_xlate_tb;

    localparam int BASE  = 5;
    localparam int NUM   = 16;
    localparam int FIRST = BASE + 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_rdata;
    logic [NUM-1:0] irq_pulse;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    msi_irq_xlate #(.BASE_SPI(BASE), .NUM_LINES(NUM)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_size(bus_size),
        .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NUM-1:0] exp_pulse(input int id);
        if (id >= FIRST && id < FIRST + NUM)
            return NUM'(1) << (id - FIRST);
        return '0;
    endfunction

    function automatic logic [31:0] exp_read(input int ofs);
        if (ofs == 'h008) return (32'(FIRST) << 16) | 32'(NUM);
        if (ofs == 'hFCC) return 32'h0510_0000;
        return '0;
    endfunction

    // one write; returns the pulse seen the cycle after, then checks it drops
    task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                            input logic [2:0] sz, input string req,
                            input logic [NUM-1:0] exp);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk(req, 32'(irq_pulse), 32'(exp));
        @(negedge clk);
        chk(req, 32'(irq_pulse), 32'd0);
    endtask

    task automatic do_read(input logic [11:0] a, input logic [2:0] sz,
                           output logic [31:0] got);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        got = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        chk("R1", 32'(irq_pulse), 32'd0);
        chk("R1", bus_rdata, 32'd0);
        rst_n = 1'b1;

        // R3 / R4: every possible id, 4-byte writes, upper bits junk
        for (int id = 0; id < 1024; id++)
            do_write(12'h040, {22'h2AAAAA, 10'(id)}, 3'd4,
                     (id >= FIRST && id < FIRST + NUM) ? "R3" : "R4",
                     exp_pulse(id));

        // R5: 2-byte writes with upper half all ones
        for (int id = FIRST - 1; id <= FIRST + NUM; id++)
            do_write(12'h040, {16'hFFFF, 6'd0, 10'(id)}, 3'd2, "R5", exp_pulse(id));
        for (int sz = 0; sz < 8; sz++)
            do_write(12'h040, 32'(FIRST + 3), 3'(sz), "R5",
                     (sz == 2 || sz == 4) ? exp_pulse(FIRST + 3) : '0);

        // R9: writes elsewhere
        do_write(12'h000, 32'(FIRST), 3'd4, "R9", '0);
        do_write(12'h008, 32'(FIRST), 3'd4, "R9", '0);
        do_write(12'h044, 32'(FIRST), 3'd4, "R9", '0);
        do_write(12'h041, 32'(FIRST), 3'd4, "R9", '0);
        do_write(12'hFCC, 32'(FIRST), 3'd4, "R9", '0);

        // R10: back-to-back doorbell writes
        @(negedge clk);
        bus_addr = 12'h040; bus_size = 3'd4; bus_wdata = 32'(FIRST); bus_wr = 1'b1;
        @(negedge clk);
        bus_wdata = 32'(FIRST + NUM - 1);
        chk("R10", 32'(irq_pulse), 32'(exp_pulse(FIRST)));
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R10", 32'(irq_pulse), 32'(exp_pulse(FIRST + NUM - 1)));
        @(negedge clk);
        chk("R10", 32'(irq_pulse), 32'd0);

        // R2 / R6 / R7 / R9: every word offset
        for (int ofs = 0; ofs < 4096; ofs += 4) begin
            do_read(12'(ofs), 3'd4, rd);
            if (ofs == 'h008)      chk("R2", rd, exp_read(ofs));
            else if (ofs == 'hFCC) chk("R6", rd, exp_read(ofs));
            else if (ofs >= 'hFD0) chk("R7", rd, exp_read(ofs));
            else                   chk("R9", rd, exp_read(ofs));
        end
        do_read(12'h009, 3'd4, rd);
        chk("R9", rd, 32'd0);

        // R8: read sizes
        for (int sz = 0; sz < 8; sz++) begin
            do_read(12'h008, 3'(sz), rd);
            chk("R8", rd, (sz == 4) ? exp_read('h008) : 32'd0);
        end

        // R11: reported geometry respects the limits
        do_read(12'h008, 3'd4, rd);
        chk("R11", 32'((rd[15:0] <= 16'd128) && (32'(rd[31:16]) + 32'(rd[15:0]) <= 32'd1020)), 32'd1);

        // R12: read data holds across idle and write cycles
        do_read(12'hFCC, 3'd4, rd);
        do_write(12'h040, 32'(FIRST + 1), 3'd4, "R3", exp_pulse(FIRST + 1));
        repeat (3) @(negedge clk);
        chk("R12", bus_rdata, 32'h0510_0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule